// File: doc/BRIEF.md
# Time Mark Generator With Test Multiplexing

This block drives the timing mark line of a receiver. In normal use it counts a 40 MHz reference clock and emits a single-cycle pulse once per second. For test, a control word can put one of two other signals on the same line. The first is a square tone at the reference divided by 91, about 439.56 kHz, used to measure oscillator drift. The second is a correlator channel's dump strobe, passed through for fault finding.

The same control word also picks which of three feedback lines, returned from the external mark line drivers, is reflected in a registered status bit. Software can read that bit to confirm that a driver really toggles. Both counters run freely from reset, whichever source is selected, so switching between sources never disturbs the one-second phase. Both outputs are registered, which gives every source one cycle of latency.

Top module: `timemark_gen`

## Requirements
- R1: With ctrl_reg bits 4 and 8 both 0, mark_out is high for exactly one cycle after the PERIOD_CYCLES-th rising clock edge following reset release, and again every PERIOD_CYCLES edges after that (default 40,000,000 edges, one second at 40 MHz).
- R2: With ctrl_reg bit 4 = 1 and bit 8 = 0, mark_out carries the reference divided by TONE_DIV (default 91). After reset release it is high after edges 1 to 45 and low after edges 46 to 91, and this 45-high/46-low pattern repeats.
- R3: With ctrl_reg bit 8 = 1, whatever bit 4 holds, mark_out equals the dump_strobe value sampled at the previous rising edge.
- R4: Both counters keep running whichever source is selected, so a return to the normal mark or the tone keeps the phase counted from reset release.
- R5: fb_status is registered and equals the OR of drv_fb[i] AND ctrl_reg[5+i] for i = 0..2. Bit 5 enables drv_fb[0], bit 6 enables drv_fb[1] and bit 7 enables drv_fb[2].
- R6: With ctrl_reg bits 7 to 5 all 0, fb_status is 0 whatever the feedback lines do.
- R7: While rst is high at a rising edge, mark_out and fb_status are 0 after that edge. Both counters restart, so the first mark again follows the PERIOD_CYCLES-th edge after release.
- R8: ctrl_reg bits 3 to 0 and bits above 8 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 40 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_reg | input | CTRL_W | Control word: bit 4 selects the tone, bit 8 selects the dump strobe, bits 7 to 5 enable the feedback lines |
| dump_strobe | input | 1 | Channel dump pulse offered as a test source |
| drv_fb | input | 3 | Feedback lines from the external line drivers |
| mark_out | output | 1 | Multiplexed timing mark |
| fb_status | output | 1 | Registered OR of the enabled feedback lines |

## Verification
A counter that is off by one shows at the ports on its first terminal count. For the mark this is one period after reset; for the tone it is at the first high-to-low change, after edge 45. A wrong source decode or priority changes mark_out one cycle after the control word changes. Phase lost while another source was selected shows at the next mark after the return. A wrong feedback enable shows in fb_status one cycle after the enable or line pattern that exposes it.

// File: rtl/tm_pkg.sv
package tm_pkg;

  typedef enum logic [1:0] {
    SRC_MARK = 2'd0,
    SRC_TONE = 2'd1,
    SRC_DUMP = 2'd2
  } tm_src_e;

  // Dump select wins over tone select.
  function automatic tm_src_e decode_src(input logic tone_bit, input logic dump_bit);
    if (dump_bit)      return SRC_DUMP;
    else if (tone_bit) return SRC_TONE;
    else               return SRC_MARK;
  endfunction

  // Status is the OR of every line whose enable is set.
  function automatic logic fb_merge(input logic [2:0] lines, input logic [2:0] enables);
    return |(lines & enables);
  endfunction

endpackage

// File: rtl/tm_period_counter.sv
module tm_period_counter #(
  parameter int PERIOD_CYCLES = 40_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CNT_W = $clog2(PERIOD_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             at_last;

  assign at_last = (cnt == LAST);
  assign tick    = at_last;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (at_last) cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R1
  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R1
  AST_MARK_WRAP: assert property (@(posedge clk) disable iff (rst)
    at_last |=> (cnt == '0)); // R4
endmodule

// File: rtl/tm_tone_divider.sv
module tm_tone_divider #(
  parameter int TONE_DIV = 91
) (
  input  logic clk,
  input  logic rst,
  output logic level
);
  localparam int CNT_W  = $clog2(TONE_DIV);
  localparam int HIGH_N = TONE_DIV / 2;
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(TONE_DIV - 1);
  localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_N);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  assign wrap  = (cnt == LAST);
  assign level = (cnt < HIGH_C);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (wrap) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  AST_TONE_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R2
  AST_TONE_WRAP: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0)); // R2
  AST_TONE_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(level) |-> (cnt == '0)); // R2
endmodule

// File: rtl/tm_out_select.sv
module tm_out_select
  import tm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_tone,
  input  logic       sel_dump,
  input  logic [2:0] fb_en,
  input  logic       mark_tick,
  input  logic       tone_level,
  input  logic       dump_strobe,
  input  logic [2:0] drv_fb,
  output logic       mark_out,
  output logic       fb_status
);
  tm_src_e src;
  logic    next_mark;
  logic    next_fb;

  assign src     = decode_src(sel_tone, sel_dump);
  assign next_fb = fb_merge(drv_fb, fb_en);

  always_comb begin
    unique case (src)
      SRC_TONE: next_mark = tone_level;
      SRC_DUMP: next_mark = dump_strobe;
      default:  next_mark = mark_tick;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mark_out  <= 1'b0;
      fb_status <= 1'b0;
    end else begin
      mark_out  <= next_mark;
      fb_status <= next_fb;
    end
  end

  AST_DUMP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    sel_dump |=> (mark_out == $past(dump_strobe))); // R3
  AST_FB_SEEN: assert property (@(posedge clk) disable iff (rst)
    (|(fb_en & drv_fb)) |=> fb_status); // R5
  AST_FB_IDLE: assert property (@(posedge clk) disable iff (rst)
    (fb_en == 3'b000) |=> !fb_status); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!mark_out && !fb_status)); // R7
endmodule

// File: rtl/timemark_gen.sv
module timemark_gen #(
  parameter int PERIOD_CYCLES = 40_000_000,
  parameter int TONE_DIV      = 91,
  parameter int CTRL_W        = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_reg,
  input  logic              dump_strobe,
  input  logic [2:0]        drv_fb,
  output logic              mark_out,
  output logic              fb_status
);
  localparam int TONE_BIT = 4;
  localparam int DUMP_BIT = 8;
  localparam int FB_LSB   = 5;

  logic       mark_tick;
  logic       tone_level;
  logic       sel_tone;
  logic       sel_dump;
  logic [2:0] fb_en;
  logic       ctrl_unused;

  assign sel_tone    = ctrl_reg[TONE_BIT];
  assign sel_dump    = ctrl_reg[DUMP_BIT];
  assign fb_en       = ctrl_reg[FB_LSB +: 3];
  assign ctrl_unused = ^{ctrl_reg[3:0], ctrl_reg[CTRL_W-1:DUMP_BIT+1]}; // R8

  tm_period_counter #(.PERIOD_CYCLES(PERIOD_CYCLES)) u_second (
    .clk  (clk),
    .rst  (rst),
    .tick (mark_tick)
  );

  tm_tone_divider #(.TONE_DIV(TONE_DIV)) u_tone (
    .clk   (clk),
    .rst   (rst),
    .level (tone_level)
  );

  tm_out_select u_sel (
    .clk         (clk),
    .rst         (rst),
    .sel_tone    (sel_tone),
    .sel_dump    (sel_dump),
    .fb_en       (fb_en),
    .mark_tick   (mark_tick),
    .tone_level  (tone_level),
    .dump_strobe (dump_strobe),
    .drv_fb      (drv_fb),
    .mark_out    (mark_out),
    .fb_status   (fb_status)
  );
endmodule

// File: tb/timemark_gen_tb.sv
module timemark_gen_tb;
  localparam int P    = 50;
  localparam int DIV  = 91;
  localparam int HI   = 45;
  localparam logic [15:0] JUNK = 16'hFE0F; // R8: bits the block must ignore

  // {enables for drv_fb[2:0], drv_fb[2:0], expected fb_status}
  localparam logic [6:0] FB_VEC [8] = '{
    7'b000_111_0, 7'b001_001_1, 7'b001_110_0, 7'b010_010_1,
    7'b100_011_0, 7'b100_100_1, 7'b111_000_0, 7'b101_010_0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ctrl_reg = '0;
  logic        dump_strobe = 1'b0;
  logic [2:0]  drv_fb = '0;
  logic        mark_out;
  logic        fb_status;
  int          checks = 0;
  int          errors = 0;
  int          cyc = 0;

  always #2 clk = ~clk;

  timemark_gen #(.PERIOD_CYCLES(P), .TONE_DIV(DIV), .CTRL_W(16)) u_dut (
    .clk(clk), .rst(rst), .ctrl_reg(ctrl_reg), .dump_strobe(dump_strobe),
    .drv_fb(drv_fb), .mark_out(mark_out), .fb_status(fb_status)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog R1 actual=%0d expected<=%0d", cyc, 20000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input logic [15:0] c, input logic [2:0] f, input logic d,
                      input logic em, input logic ef, input string rm, input string rf);
    ctrl_reg = c; drv_fb = f; dump_strobe = d;
    @(posedge clk);
    @(negedge clk);
    check(mark_out, em, rm);
    check(fb_status, ef, rf);
  endtask

  // mode: 0 normal mark, 1 tone, 2 dump, 3 tone bit plus dump bit
  task automatic run_span(input int j0, input int j1, input int mode, input string rm);
    for (int j = j0; j < j1; j++) begin
      logic [6:0]  v;
      logic [15:0] c;
      logic        d;
      logic        em;
      v  = FB_VEC[j % 8];
      d  = ((j % 3) == 0) || ((j % 7) == 1);
      c  = JUNK | {7'd0, 1'b0, v[6:4], 5'd0};
      if (mode == 1) c[4] = 1'b1;
      if (mode >= 2) c[8] = 1'b1;
      if (mode == 3) c[4] = 1'b1;
      if (mode == 0)      em = ((j % P) == P - 1);
      else if (mode == 1) em = ((j % DIV) < HI);
      else                em = d;
      step(c, v[3:1], d, em, v[0], rm, (v[6:4] == 3'b000) ? "R6 fb idle" : "R5 fb select");
    end
  endtask

  task automatic hold_reset(input int n);
    rst = 1'b1;
    ctrl_reg = 16'h01F0; drv_fb = 3'b111; dump_strobe = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check(mark_out, 1'b0, "R7 reset mark");
      check(fb_status, 1'b0, "R7 reset status");
    end
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    hold_reset(3);
    run_span(0, 120, 0, "R1 normal mark");
    run_span(120, 320, 1, "R2 tone");
    run_span(320, 350, 2, "R3 dump");
    run_span(350, 370, 3, "R3 dump priority");
    run_span(370, 470, 0, "R4 phase kept");
    run_span(470, 560, 1, "R4 tone phase");
    // mid-run reset, then the mark must again wait a full period
    hold_reset(2);
    run_span(0, P + 5, 0, "R7 restart");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule